// File: doc/BRIEF.md
# Slot-Scheduled Video Write FIFO

This block sits between a host processor and a video memory controller. It queues host writes, each made of a 16-bit data word and a target code, and hands them to the memory side only at fixed access positions inside every scan line. One clock of the block is one master cycle. An internal position counter runs across a line of 3420 master cycles, and the horizontal mode input selects one of two fixed slot patterns.

A target code whose low four bits are 2 or less names a video-RAM target. Video RAM is reached one byte at a time, so such an entry needs two slots before it retires. Any other target retires in a single slot. The block drives full and empty flags. When the host writes while the queue is full, the block holds the host with a stall signal until a retirement frees a place, and it takes the write in that same cycle. A frame-start pulse flushes the queue and puts the position counter back to zero.

Top module: `vslot_write_fifo`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `fifo_empty` is 1 and `fifo_full`, `wr_stall` and `rd_valid` are 0. The line position starts at 0.
- R2: The line position advances by one every clock and wraps from 3419 to 0. With `wide_mode` at 0, slots occur at positions 230, 510, 810, 970, 1130, 1450, 1610, 1770, 2090, 2250, 2410, 2730, 2890, 3050, 3350 and 3370. An entry retires only in a slot cycle, and it is presented on `rd_valid`/`rd_code`/`rd_data` in that same cycle.
- R3: With `wide_mode` at 1, the 18 slots are at positions 352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972, 2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364 and 3380.
- R4: An entry whose code has low nibble 0, 1 or 2 retires at the second slot that finds it at the head of the queue. Any other code retires at the first such slot.
- R5: When one slot of a two-slot entry has elapsed, that half is kept until the next slot and is not lost. A slot that passes while the queue is empty earns nothing.
- R6: A write offered while the queue is not full is accepted. It raises the occupancy by one and clears `fifo_empty`, and `fifo_full` is set once the occupancy reaches 4.
- R7: A retirement clears `fifo_full` unless a write is accepted in the same cycle. `fifo_empty` is set when the occupancy reaches 0, and no retirement happens while the queue is empty.
- R8: A write offered while the queue is full raises `wr_stall` in every cycle without a retirement. In the cycle of the next retirement the stall drops and the write is accepted.
- R9: Entries leave in the order they arrived. An accepted write and a retirement in the same cycle leave the occupancy unchanged.
- R10: A `frame_start` cycle discards every queued entry and any half-used slot, and it returns the position to 0 on the next clock. In that cycle no entry retires, no write is accepted and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse; flushes the queue and restarts the line |
| wide_mode | input | 1 | Horizontal mode: 0 narrow (16 slots), 1 wide (18 slots) |
| wr_valid | input | 1 | Host offers a write this cycle |
| wr_code | input | 4 | Target code of the offered write |
| wr_data | input | 16 | Data word of the offered write |
| wr_stall | output | 1 | Host must hold its write; queue full and nothing retires |
| rd_valid | output | 1 | An entry retires to the memory side this cycle |
| rd_code | output | 4 | Target code of the retiring entry |
| rd_data | output | 16 | Data word of the retiring entry |
| fifo_full | output | 1 | Status: occupancy equals the queue depth |
| fifo_empty | output | 1 | Status: occupancy is zero |

## Verification
Retirement, the retired entry's fields and the stall are combinational from registered state, so they are due in the same cycle in which the position counter shows a slot. The flags and the occupancy follow one clock edge after an accept or a retirement. The bench drives its inputs just after the falling edge and samples all outputs a short time later, before the rising edge. It advances its own line-position and queue model only at the rising edge, so every expected value belongs to the cycle that is being sampled. Directed cases then record the position at which a retirement or an accept took place and compare it with the slot tables.

// File: rtl/vslot_pkg.sv
package vslot_pkg;

   localparam int unsigned NARROW_SLOTS = 16;
   localparam int unsigned WIDE_SLOTS   = 18;

   typedef enum logic {
      HMODE_NARROW = 1'b0,
      HMODE_WIDE   = 1'b1
   } hmode_e;

   // slot positions (master cycles from line start), narrow mode
   function automatic int unsigned narrow_slot_pos(input int unsigned idx);
      case (idx)
         0:  return 230;
         1:  return 510;
         2:  return 810;
         3:  return 970;
         4:  return 1130;
         5:  return 1450;
         6:  return 1610;
         7:  return 1770;
         8:  return 2090;
         9:  return 2250;
         10: return 2410;
         11: return 2730;
         12: return 2890;
         13: return 3050;
         14: return 3350;
         15: return 3370;
         default: return 0;
      endcase
   endfunction

   // slot positions, wide mode
   function automatic int unsigned wide_slot_pos(input int unsigned idx);
      case (idx)
         0:  return 352;
         1:  return 820;
         2:  return 948;
         3:  return 1076;
         4:  return 1332;
         5:  return 1460;
         6:  return 1588;
         7:  return 1844;
         8:  return 1972;
         9:  return 2100;
         10: return 2356;
         11: return 2484;
         12: return 2612;
         13: return 2868;
         14: return 2996;
         15: return 3124;
         16: return 3364;
         17: return 3380;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/vslot_line_timer.sv
module vslot_line_timer #(
   parameter int unsigned LINE_CYCLES = 3420
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  vslot_pkg::hmode_e hmode,
   output logic              slot_hit
);
   import vslot_pkg::*;

   localparam int unsigned POS_W = $clog2(LINE_CYCLES);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_CYCLES - 1);

   if (LINE_CYCLES < 2) begin : g_bad_line
      $error("vslot_line_timer: LINE_CYCLES must be at least 2");
   end

   logic [POS_W-1:0]        line_pos;
   logic [NARROW_SLOTS-1:0] n_hit;
   logic [WIDE_SLOTS-1:0]   w_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_pos <= '0;
      else if (frame_start || line_pos == LAST_POS)
         line_pos <= '0;
      else
         line_pos <= line_pos + POS_W'(1);
   end

   for (genvar gi = 0; gi < NARROW_SLOTS; gi++) begin : g_narrow
      if (narrow_slot_pos(gi) >= LINE_CYCLES) begin : g_chk
         $error("vslot_line_timer: narrow slot beyond line end");
      end
      assign n_hit[gi] = (line_pos == POS_W'(narrow_slot_pos(gi)));
   end

   for (genvar gi = 0; gi < WIDE_SLOTS; gi++) begin : g_wide
      if (wide_slot_pos(gi) >= LINE_CYCLES) begin : g_chk
         $error("vslot_line_timer: wide slot beyond line end");
      end
      assign w_hit[gi] = (line_pos == POS_W'(wide_slot_pos(gi)));
   end

   always_comb begin
      if (hmode == HMODE_WIDE)
         slot_hit = |w_hit;
      else
         slot_hit = |n_hit;
   end

   a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pos == LAST_POS) |=> (line_pos == '0));
   a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && line_pos != LAST_POS) |=> (line_pos == $past(line_pos) + POS_W'(1)));
   a_r10_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (line_pos == '0));
   a_r2_narrow_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(n_hit));
   a_r3_wide_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(w_hit));

endmodule

// File: rtl/vslot_cost_gate.sv
module vslot_cost_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic slot_hit,
   input  logic have_entry,
   input  logic head_two_slot,
   output logic retire
);
   logic half_done;

   assign retire = !flush && slot_hit && have_entry && (!head_two_slot || half_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         half_done <= 1'b0;
      else if (flush || retire)
         half_done <= 1'b0;
      else if (slot_hit && have_entry && head_two_slot)
         half_done <= 1'b1;
   end

   a_r5_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (half_done && !slot_hit && !flush) |=> half_done);
   a_r5_half_owner: assert property (@(posedge clk) disable iff (!rst_n)
      half_done |-> (have_entry && head_two_slot));
   a_r4_first_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_done && head_two_slot) |-> !retire);
   a_r7_no_empty_retire: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> have_entry);

endmodule

// File: rtl/vslot_entry_queue.sv
module vslot_entry_queue #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned WIDTH = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wr_entry,
   input  logic             pop,
   output logic [WIDTH-1:0] head_entry,
   output logic             is_full,
   output logic             is_empty
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("vslot_entry_queue: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vslot_entry_queue: WIDTH must be positive");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count, count_n;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
   endfunction

   always_comb begin
      count_n = count;
      if (flush) begin
         count_n = '0;
      end else begin
         if (push) count_n = count_n + CNT_W'(1);
         if (pop)  count_n = count_n - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         is_full  <= 1'b0;
         is_empty <= 1'b1;
      end else begin
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
         end
         count    <= count_n;
         is_full  <= (count_n == CNT_W'(DEPTH));
         is_empty <= (count_n == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush)
         store[wr_ptr] <= wr_entry;
   end

   assign head_entry = store[rd_ptr];

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && is_full && !flush) |-> pop);
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !is_empty);
   a_r9_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && push && pop) |=> (count == $past(count)));
   a_r6_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      is_full == (count == CNT_W'(DEPTH)));
   a_r7_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty == (count == '0));

endmodule

// File: rtl/vslot_write_fifo.sv
module vslot_write_fifo #(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned CODE_W        = 4,
   parameter int unsigned DEPTH         = 4,
   parameter int unsigned LINE_CYCLES   = 3420,
   parameter int unsigned BYTE_CODE_MAX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              wide_mode,
   input  logic              wr_valid,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_stall,
   output logic              rd_valid,
   output logic [CODE_W-1:0] rd_code,
   output logic [DATA_W-1:0] rd_data,
   output logic              fifo_full,
   output logic              fifo_empty
);
   localparam int unsigned ENTRY_W = 1 + CODE_W + DATA_W;

   if (BYTE_CODE_MAX > 15) begin : g_bad_code_max
      $error("vslot_write_fifo: BYTE_CODE_MAX must fit a nibble");
   end

   logic               slot_hit, retire, accept, two_slot_in;
   logic [ENTRY_W-1:0] head_entry;

   // the two-slot class is decided by the low nibble of the code
   if (CODE_W > 4) begin : g_long_code
      assign two_slot_in = (wr_code[3:0] <= 4'(BYTE_CODE_MAX));
   end else begin : g_short_code
      assign two_slot_in = (wr_code <= CODE_W'(BYTE_CODE_MAX));
   end

   vslot_line_timer #(.LINE_CYCLES(LINE_CYCLES)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .hmode       (vslot_pkg::hmode_e'(wide_mode)),
      .slot_hit    (slot_hit)
   );

   vslot_cost_gate u_cost (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (frame_start),
      .slot_hit      (slot_hit),
      .have_entry    (!fifo_empty),
      .head_two_slot (head_entry[ENTRY_W-1]),
      .retire        (retire)
   );

   assign accept   = wr_valid && !frame_start && (!fifo_full || retire);
   assign wr_stall = wr_valid && !frame_start && fifo_full && !retire;

   vslot_entry_queue #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (frame_start),
      .push       (accept),
      .wr_entry   ({two_slot_in, wr_code, wr_data}),
      .pop        (retire),
      .head_entry (head_entry),
      .is_full    (fifo_full),
      .is_empty   (fifo_empty)
   );

   assign rd_valid = retire;
   assign rd_code  = head_entry[DATA_W +: CODE_W];
   assign rd_data  = head_entry[DATA_W-1:0];

   a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stall |-> (fifo_full && !rd_valid));
   a_r8_stall_to_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && fifo_full && rd_valid && !frame_start) |=> fifo_full);
   a_r7_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !wr_valid) |=> !fifo_full);
   a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (fifo_empty && !fifo_full));

endmodule

// File: tb/test_vslot_write_fifo.sv
module test_vslot_write_fifo;
   localparam int LINE  = 3420;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        wide_mode = 1'b0;
   logic        wr_valid = 1'b0;
   logic [3:0]  wr_code = '0;
   logic [15:0] wr_data = '0;
   logic        wr_stall, rd_valid, fifo_full, fifo_empty;
   logic [3:0]  rd_code;
   logic [15:0] rd_data;

   vslot_write_fifo i_vslot_write_fifo (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wide_mode(wide_mode),
      .wr_valid(wr_valid), .wr_code(wr_code), .wr_data(wr_data), .wr_stall(wr_stall),
      .rd_valid(rd_valid), .rd_code(rd_code), .rd_data(rd_data),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty)
   );

   always #10 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int narrow_tab[16] = '{230, 510, 810, 970, 1130, 1450, 1610, 1770,
                          2090, 2250, 2410, 2730, 2890, 3050, 3350, 3370};
   int wide_tab[18]   = '{352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972,
                          2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364, 3380};

   // reference state: {two_slot, code, data}
   logic [20:0] mq[$];
   int  mpos = 0;
   bit  mcredit = 1'b0;
   int  last_pop_pos = -1;
   int  last_acc_pos = -1;
   bit  last_stall = 1'b0;

   function automatic bit is_slot(bit wide, int p);
      if (wide) begin
         foreach (wide_tab[k]) if (wide_tab[k] == p) return 1'b1;
      end else begin
         foreach (narrow_tab[k]) if (narrow_tab[k] == p) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", req, what, act, exp, mpos);
      end
   endtask

   task automatic cyc(input bit pv, input logic [3:0] code, input logic [15:0] data, input bit fs);
      bit hit, two, e_ret, e_stall, e_acc;
      int cnt;
      @(negedge clk);
      wr_valid = pv; wr_code = code; wr_data = data; frame_start = fs;
      #2;
      cnt = mq.size();
      hit = is_slot(wide_mode, mpos);
      two = (cnt > 0) ? mq[0][20] : 1'b0;
      e_ret   = !fs && hit && (cnt > 0) && (!two || mcredit);
      e_stall = pv && !fs && (cnt == DEPTH) && !e_ret;
      e_acc   = pv && !fs && ((cnt < DEPTH) || e_ret);
      chk(rd_valid == e_ret, wide_mode ? "R3" : "R2", "rd_valid", rd_valid, e_ret);
      if (e_ret) begin
         chk(rd_data == mq[0][15:0], "R9", "rd_data", rd_data, mq[0][15:0]);
         chk(rd_code == mq[0][19:16], "R9", "rd_code", rd_code, mq[0][19:16]);
         last_pop_pos = mpos;
      end
      chk(wr_stall == e_stall, "R8", "wr_stall", wr_stall, e_stall);
      chk(fifo_full == (cnt == DEPTH), "R6", "fifo_full", fifo_full, cnt == DEPTH);
      chk(fifo_empty == (cnt == 0), "R7", "fifo_empty", fifo_empty, cnt == 0);
      last_stall = e_stall;
      if (e_acc) last_acc_pos = mpos;
      @(posedge clk);
      if (fs) begin
         mq.delete();
         mcredit = 1'b0;
         mpos = 0;
      end else begin
         if (e_ret) begin
            void'(mq.pop_front());
            mcredit = 1'b0;
         end else if (hit && cnt > 0 && two) begin
            mcredit = 1'b1;
         end
         if (e_acc) mq.push_back({(code <= 4'd2), code, data});
         mpos = (mpos == LINE - 1) ? 0 : mpos + 1;
      end
   endtask

   task automatic idle_to(input int target);
      while (mpos != target) cyc(1'b0, 4'd0, 16'd0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int acc_pos;
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(fifo_empty == 1'b1, "R1", "empty in reset", fifo_empty, 1);
      chk(fifo_full == 1'b0, "R1", "full in reset", fifo_full, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk(fifo_empty == 1'b1, "R1", "empty after reset", fifo_empty, 1);
      chk(wr_stall == 1'b0 && rd_valid == 1'b0, "R1", "stall/rd after reset", wr_stall | rd_valid, 0);
      @(posedge clk);
      mpos = 1;

      // R4: video-RAM word pushed at position 0 retires at the second narrow slot
      cyc(1'b0, 4'd0, 16'd0, 1'b1);
      last_pop_pos = -1;
      cyc(1'b1, 4'd1, 16'hA5A5, 1'b0);
      idle_to(600);
      chk(last_pop_pos == 510, "R4", "two-slot retire pos", last_pop_pos, 510);

      // R5: slot passing while empty earns no half credit
      cyc(1'b0, 4'd0, 16'd0, 1'b1);
      idle_to(300);
      last_pop_pos = -1;
      cyc(1'b1, 4'd0, 16'h1234, 1'b0);
      idle_to(900);
      chk(last_pop_pos == 810, "R5", "credit carry retire pos", last_pop_pos, 810);

      // R3 and R4: one-slot target in wide mode retires at the first wide slot
      wide_mode = 1'b1;
      cyc(1'b0, 4'd0, 16'd0, 1'b1);
      last_pop_pos = -1;
      cyc(1'b1, 4'd5, 16'h0F0F, 1'b0);
      idle_to(400);
      chk(last_pop_pos == 352, "R3", "one-slot wide retire pos", last_pop_pos, 352);

      // R8 and R6: fifth video-RAM write stalls until the second narrow slot
      wide_mode = 1'b0;
      cyc(1'b0, 4'd0, 16'd0, 1'b1);
      for (int k = 0; k < DEPTH; k++) cyc(1'b1, 4'd1, 16'(16'h100 + k), 1'b0);
      #2;
      chk(fifo_full == 1'b1, "R6", "full after four writes", fifo_full, 1);
      cyc(1'b1, 4'd1, 16'h0200, 1'b0);
      while (last_stall) cyc(1'b1, 4'd1, 16'h0200, 1'b0);
      acc_pos = last_acc_pos;
      chk(acc_pos == 510, "R8", "stalled write accept pos", acc_pos, 510);

      // R10: frame start flushes a full queue
      cyc(1'b0, 4'd0, 16'd0, 1'b1);
      #2;
      chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R10", "flush flags", fifo_empty, 1);
      chk(mpos == 0, "R10", "model restart", mpos, 0);

      // sweeps over both modes and four traffic patterns, across a line wrap
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 4; p++) begin
            logic [3:0]  c;
            logic [15:0] d;
            bit          v;
            wide_mode = m[0];
            cyc(1'b0, 4'd0, 16'd0, 1'b1);
            c = 4'd0; d = 16'd0;
            for (int i = 0; i < LINE + 400; i++) begin
               if (!last_stall) begin
                  case (p)
                     0: begin v = 1'b1; c = 4'(i % 3); end
                     1: begin v = 1'b1; c = 4'(3 + (i % 13)); end
                     2: begin v = ((i * 7) % 11) < 3; c = 4'(i % 16); end
                     default: begin v = ((i * 5) % 9) < 4; c = 4'((i * 3) % 16); end
                  endcase
                  d = 16'(i ^ (p << 12) ^ (m << 15));
               end else begin
                  v = 1'b1;
               end
               cyc(v, c, d, (p == 3) && (i == 1700));
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule